// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block is the mode-sequencing core of an on-chip clock generator. It tracks which of six operating modes the generator is in and moves between them only when software-style control inputs request a transition that is on an allowed path. The controls are a two-bit output-source select, a PLL/FLL select bit, a low-power bit, a reference divider code and a VCO divider code. The oscillators, the PLL and the FLL are not modelled. Each source switch is represented by a fixed settling latency on the status outputs.

Software changes one control at a time and polls the status outputs until they report the expected source. The status outputs trail the mode by a parameterised number of clock edges. Any request off the allowed paths is refused and recorded in a sticky flag. A request to enter the FLL-bypassed external mode while the reference divider is invalid is also refused and recorded. A separate flag reports divider codes that are out of range.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: While reset is low, and after it is released, the outputs are: mode = 0 (FLL bypassed internal), src_stat = 2'b01, pll_stat = 0, illegal = 0 and div_err = 0.
- R2: Mode codes are: 0 FLL bypassed internal (FBI), 1 FLL bypassed external (FBE), 2 PLL bypassed external (PBE), 3 PLL engaged external (PEE), 4 low-power internal bypass (BLPI) and 5 low-power external bypass (BLPE). The controls decode to a requested mode as follows:
  - src_sel=10 with low_pwr=1 requests BLPE.
  - src_sel=10 with low_pwr=0 requests PBE if pll_sel=1, and FBE otherwise.
  - src_sel=01 requests BLPI if low_pwr=1, and FBI otherwise.
  - src_sel=00 with pll_sel=1 and low_pwr=0 requests PEE.

  A legal request becomes the mode on the next rising clock edge.
- R3: The allowed moves, in either direction, are PEE–PBE, PBE–BLPE, PBE–FBE, BLPE–FBE, FBE–FBI and FBI–BLPI. Two kinds of request are refused: a move to any other mode, and a control combination that decodes to no mode. A refused request leaves the mode unchanged and sets illegal. illegal stays set until reset.
- R4: src_stat reads 2'b00 for PEE, 2'b10 for PBE, FBE and BLPE, and 2'b01 for FBI and BLPI. It takes the new code exactly LATENCY (default 4) clock edges after the edge on which mode changed.
- R5: pll_stat reads 1 for PEE and PBE, and 0 for FBE, FBI and BLPI. It follows the same LATENCY-edge delay as src_stat.
- R6: In BLPE, pll_stat keeps the value of the mode BLPE was entered from, whatever pll_sel does. A pll_sel value written while in BLPE takes effect on leaving BLPE: pll_sel=0 leads to FBE and pll_stat then becomes 0.
- R7: A move into FBE needs ref_div = 3'b010 (division by 128, which gives a 31.25 kHz reference from 4 MHz). With any other code the move is refused, the mode is held and illegal is set.
- R8: div_err, one clock edge after sampling, is 1 in either of two cases: ref_div is not 3'b010, or pll_sel = 1 and vco_div > 24.
- R9: When pll_sel = 0, vco_div has no effect on div_err. vco_div never affects the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Output source select: 00 PLL/FLL, 01 internal ref, 10 external ref |
| pll_sel | input | 1 | 1 selects PLL, 0 selects FLL |
| low_pwr | input | 1 | Low-power bypass request |
| ref_div | input | 3 | Reference divider code |
| vco_div | input | 5 | VCO divider code |
| mode | output | 3 | Current mode code |
| src_stat | output | 2 | Delayed output-source status |
| pll_stat | output | 1 | Delayed PLL-select status |
| div_err | output | 1 | Divider code out of range |
| illegal | output | 1 | Sticky refused-transition flag |

## Verification
Four properties are checked on every cycle:
- every mode change follows an allowed edge;
- the mode code stays in range;
- illegal never clears without reset;
- entry into FBE happens only with a valid divider code.

Once the mode has been steady for LATENCY cycles, assertions also tie src_stat to the mode and keep pll_stat still inside BLPE. Other behaviour can only be seen in the bench's scenarios:
- the exact edge on which status flips;
- a pll_sel value deferred through BLPE and applied on exit;
- refusal of an FBE entry with a bad divider;
- vco_div having no effect when the FLL is selected.

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl #(
  parameter int LATENCY    = 4,
  parameter int RDIV_W     = 3,
  parameter int VDIV_W     = 5,
  parameter int REF_DIV_OK = 2,
  parameter int VDIV_MAX   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_sel,
  input  logic              pll_sel,
  input  logic              low_pwr,
  input  logic [RDIV_W-1:0] ref_div,
  input  logic [VDIV_W-1:0] vco_div,
  output logic [2:0]        mode,
  output logic [1:0]        src_stat,
  output logic              pll_stat,
  output logic              div_err,
  output logic              illegal
);
  localparam logic [2:0] M_FBI = 3'd0, M_FBE = 3'd1, M_PBE = 3'd2,
                         M_PEE = 3'd3, M_BLPI = 3'd4, M_BLPE = 3'd5;
  localparam int PW = 3;
  localparam int CW = $clog2(LATENCY + 1);
  localparam logic [RDIV_W-1:0] RDIV_GOOD = RDIV_W'(REF_DIV_OK);
  localparam logic [VDIV_W-1:0] VDIV_TOP  = VDIV_W'(VDIV_MAX);
  localparam logic [CW-1:0]     SETTLED   = CW'(LATENCY);

  function automatic logic [3:0] decode(input logic [1:0] s, input logic p, input logic l);
    case (s)
      2'b10:   return l ? {1'b1, M_BLPE} : (p ? {1'b1, M_PBE} : {1'b1, M_FBE});
      2'b01:   return l ? {1'b1, M_BLPI} : {1'b1, M_FBI};
      2'b00:   return (p && !l) ? {1'b1, M_PEE} : 4'b0000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic allowed(input logic [2:0] a, input logic [2:0] b);
    case ({a, b})
      {M_PEE, M_PBE},  {M_PBE, M_PEE},
      {M_PBE, M_BLPE}, {M_BLPE, M_PBE},
      {M_PBE, M_FBE},  {M_FBE, M_PBE},
      {M_BLPE, M_FBE}, {M_FBE, M_BLPE},
      {M_FBE, M_FBI},  {M_FBI, M_FBE},
      {M_FBI, M_BLPI}, {M_BLPI, M_FBI}: return 1'b1;
      default: return a == b;
    endcase
  endfunction

  function automatic logic [1:0] src_code(input logic [2:0] m);
    case (m)
      M_PEE:         return 2'b00;
      M_FBI, M_BLPI: return 2'b01;
      default:       return 2'b10;
    endcase
  endfunction

  logic [3:0]           req;
  logic                 bad;
  logic [2:0]           nxt_mode;
  logic                 applied, nxt_applied;
  logic [PW*LATENCY-1:0] pipe;
  logic [PW-1:0]        tgt;

  assign req = decode(src_sel, pll_sel, low_pwr);
  assign bad = !req[3] ||
               (req[2:0] != mode && (!allowed(mode, req[2:0]) ||
                                     (req[2:0] == M_FBE && ref_div != RDIV_GOOD)));
  assign nxt_mode = bad ? mode : req[2:0];
  assign tgt = {src_code(mode), applied};

  always_comb begin
    case (nxt_mode)
      M_PEE, M_PBE: nxt_applied = 1'b1;
      M_BLPE:       nxt_applied = applied;
      default:      nxt_applied = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= M_FBI;
      applied <= 1'b0;
      illegal <= 1'b0;
      div_err <= 1'b0;
    end else begin
      mode    <= nxt_mode;
      applied <= nxt_applied;
      illegal <= illegal | bad;
      div_err <= (ref_div != RDIV_GOOD) || (pll_sel && vco_div > VDIV_TOP);
    end
  end

  generate
    if (LATENCY > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {LATENCY{3'b010}};
        else        pipe <= {pipe[PW*LATENCY-PW-1:0], tgt};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= 3'b010;
        else        pipe <= tgt;
      end
    end
  endgenerate

  assign src_stat = pipe[PW*LATENCY-1 -: 2];
  assign pll_stat = pipe[PW*LATENCY-3];

  logic [CW-1:0] settle;
  always_ff @(posedge clk) begin
    if (!rst_n)                settle <= SETTLED;
    else if (nxt_mode != mode) settle <= '0;
    else if (settle != SETTLED) settle <= settle + 1'b1;
  end

  assert_legal_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> allowed($past(mode), mode));
  assert_mode_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= M_BLPE);
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);
  assert_src_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (settle == SETTLED) |-> (src_stat == src_code(mode)));
  assert_blpe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_BLPE && $past(mode) == M_BLPE && settle == SETTLED && $past(settle) == SETTLED)
      |-> $stable(pll_stat));
  assert_fbe_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FBE && $past(mode) != M_FBE) |-> ($past(ref_div) == RDIV_GOOD));
endmodule

// File: tb/tb_clkgen_mode_ctrl.sv
module tb_clkgen_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] src_sel = 2'b01;
  logic pll_sel = 0, low_pwr = 0;
  logic [2:0] ref_div = 3'd2;
  logic [4:0] vco_div = 5'd0;
  logic [2:0] mode;
  logic [1:0] src_stat;
  logic pll_stat, div_err, illegal;

  int n_chk = 0, n_bad = 0;

  clkgen_mode_ctrl #(.LATENCY(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .pll_sel(pll_sel), .low_pwr(low_pwr),
    .ref_div(ref_div), .vco_div(vco_div), .mode(mode), .src_stat(src_stat),
    .pll_stat(pll_stat), .div_err(div_err), .illegal(illegal));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0] m_mode;
  logic m_app, m_ill, m_derr;
  logic [2:0] m_pipe [LAT];

  function automatic int want(input logic [1:0] s, input logic p, input logic l);
    if (s == 2'b01) return l ? 4 : 0;
    if (s == 2'b10) return l ? 5 : (p ? 2 : 1);
    if (s == 2'b00 && p && !l) return 3;
    return -1;
  endfunction

  function automatic bit edge_ok(input int a, input int b);
    int lo = (a < b) ? a : b;
    int hi = (a < b) ? b : a;
    if (a == b) return 1;
    return (lo == 2 && hi == 3) || (lo == 2 && hi == 5) || (lo == 1 && hi == 2) ||
           (lo == 1 && hi == 5) || (lo == 0 && hi == 1) || (lo == 0 && hi == 4);
  endfunction

  function automatic logic [1:0] exp_src(input int m);
    return (m == 3) ? 2'b00 : ((m == 0 || m == 4) ? 2'b01 : 2'b10);
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int w = want(src_sel, pll_sel, low_pwr);
    bit refuse;
    for (int i = LAT-1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
    m_pipe[0] = {exp_src(int'(m_mode)), m_app};
    refuse = (w < 0) || (w != int'(m_mode) && (!edge_ok(int'(m_mode), w) ||
             (w == 1 && ref_div != 3'd2)));
    if (!refuse) m_mode = 3'(w);
    if (m_mode == 3'd2 || m_mode == 3'd3) m_app = 1;
    else if (m_mode != 3'd5) m_app = 0;
    m_ill = m_ill | refuse;
    m_derr = (ref_div != 3'd2) || (pll_sel && vco_div > 5'd24);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R2 mode", int'(mode), int'(m_mode));
    chk("R4 src_stat", int'(src_stat), int'(m_pipe[LAT-1][2:1]));
    chk("R5 pll_stat", int'(pll_stat), int'(m_pipe[LAT-1][0]));
    chk("R3 illegal", int'(illegal), int'(m_ill));
    chk("R8 div_err", int'(div_err), int'(m_derr));
  endtask

  task automatic do_reset();
    rst_n = 0; src_sel = 2'b01; pll_sel = 0; low_pwr = 0; ref_div = 3'd2; vco_div = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_mode = 0; m_app = 0; m_ill = 0; m_derr = 0;
    for (int i = 0; i < LAT; i++) m_pipe[i] = 3'b010;
    chk("R1 mode", int'(mode), 0);
    chk("R1 src_stat", int'(src_stat), 1);
    chk("R1 pll_stat", int'(pll_stat), 0);
    chk("R1 illegal", int'(illegal), 0);
    chk("R1 div_err", int'(div_err), 0);
    rst_n = 1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4485));
    do_reset();
    tick();
    src_sel = 2'b10; tick();
    chk("R2 FBI->FBE", int'(mode), 1);
    for (int j = 1; j <= LAT; j++) begin
      tick();
      chk("R4 latency", int'(src_stat), (j < LAT) ? 1 : 2);
    end
    pll_sel = 1; ticks(LAT + 1);
    chk("R2 PBE", int'(mode), 2);
    chk("R5 pll_stat PBE", int'(pll_stat), 1);
    src_sel = 2'b00; ticks(LAT + 1);
    chk("R4 PEE src", int'(src_stat), 0);
    src_sel = 2'b10; ticks(LAT + 1);
    low_pwr = 1; ticks(LAT + 1);
    chk("R6 BLPE", int'(mode), 5);
    pll_sel = 0; ticks(LAT + 3);
    chk("R6 pll held", int'(pll_stat), 1);
    chk("R6 mode held", int'(mode), 5);
    low_pwr = 0; ticks(LAT + 1);
    chk("R6 exit FBE", int'(mode), 1);
    chk("R6 pll applied", int'(pll_stat), 0);
    chk("R3 clean path", int'(illegal), 0);

    do_reset();
    src_sel = 2'b10; ticks(2);
    pll_sel = 1; ticks(2);
    ref_div = 3'd3; pll_sel = 0; ticks(3);
    chk("R7 refused", int'(mode), 2);
    chk("R7 flag", int'(illegal), 1);
    chk("R8 ref bad", int'(div_err), 1);

    do_reset();
    vco_div = 5'd31; ticks(2);
    chk("R9 vco ignored", int'(div_err), 0);
    pll_sel = 1; ticks(2);
    chk("R8 vco high", int'(div_err), 1);
    chk("R9 mode", int'(mode), 0);
    vco_div = 5'd24; ticks(2);
    chk("R8 vco edge", int'(div_err), 0);

    do_reset();
    src_sel = 2'b00; ticks(2);
    chk("R3 no mode", int'(mode), 0);
    src_sel = 2'b01; ticks(3);
    chk("R3 sticky", int'(illegal), 1);

    do_reset();
    low_pwr = 1; ticks(2);
    src_sel = 2'b10; ticks(2);
    chk("R3 BLPI->BLPE", int'(mode), 4);

    for (int b = 0; b < 8; b++) begin
      do_reset();
      for (int c = 0; c < 80; c++) begin
        case ($urandom_range(0, 9))
          0, 1:    src_sel = 2'($urandom_range(0, 2));
          2, 3:    pll_sel = ~pll_sel;
          4, 5:    low_pwr = ~low_pwr;
          6:       ref_div = ($urandom_range(0, 4) == 0) ? 3'($urandom) : 3'd2;
          7:       vco_div = 5'($urandom);
          default: ;
        endcase
        tick();
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule